// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block gathers completion and error events from up to fifteen transmit and fifteen receive queue engines and folds them into a single interrupt line. Each event arrives as a one-cycle pulse on a per-endpoint bit vector. The pulse is latched in a status register, where it stays until software clears it by writing a one to its bit. Enable registers decide which latched bits may drive the interrupt.

Completion events land in one done register: transmit endpoints in the lower half, receive endpoints in the upper half. Error events land in three per-endpoint detail registers: transmit checksum/length, receive checksum/length, and receive zero-length packet. A read-only summary register carries one bit per error kind. A summary bit is high while some detail bit of that kind is set and enabled in its per-endpoint error-enable register. A second enable register gates the summary bits onto the interrupt. Endpoint 0 is not served, so its input bits are ignored everywhere.

Software reaches every register through a single-cycle write strobe with a word address. The read data is a combinational function of the address.

Top module: `qint_agg`

## Requirements
- R1: A transmit done pulse on endpoint n (1..15) sets bit n of the done register (address 0x0). A receive done pulse on endpoint n sets bit 16+n. The bit is visible one clock edge after the pulse.
- R2: A write to address 0x0 clears each done bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R3: When an event for a bit arrives in the same cycle as a write-1 clear of that bit, the bit ends up set. This holds for the done register and for every detail register.
- R4: Inputs for endpoint 0 never set any bit. Bits 0 and 16 of the done and error detail registers, and bit 0 of the zero-length register, always read 0.
- R5: irq_o is 1 exactly when some done bit is set with its bit set in the done-enable register (0x1), or some summary bit is set with its bit set in the exception-enable register (0x3, bits 4:0).
- R6: The summary register (0x2) reads bit0 = transmit checksum, bit1 = transmit length, bit2 = receive checksum, bit3 = receive length, bit4 = receive zero-length. Each bit is 1 while some detail bit of that kind is set and enabled. Writes to 0x2 have no effect.
- R7: Detail registers hold checksum errors in bits 15:0 (bit n for endpoint n) and length errors in bits 31:16 (bit 16+n). Transmit uses address 0x4 and receive uses 0x5. Zero-length events go to bits 15:0 of 0x6. Events are recorded whatever the error-enable settings are.
- R8: Writing ones to a detail register clears those bits. The matching summary bits fall in the same cycle the bits clear.
- R9: The enable registers read back what was written: done-enable 0x1 (32 bits), exception-enable 0x3 (bits 4:0), transmit error-enable 0x7 (32 bits), receive error-enable 0x8 (32 bits), zero-length enable 0x9 (bits 15:0). All other bits, and all unmapped addresses, read 0. Everything is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_done_i | input | 16 | Transmit done pulses, bit n for endpoint n |
| rx_done_i | input | 16 | Receive done pulses |
| tx_cs_err_i | input | 16 | Transmit checksum error pulses |
| tx_len_err_i | input | 16 | Transmit length error pulses |
| rx_cs_err_i | input | 16 | Receive checksum error pulses |
| rx_len_err_i | input | 16 | Receive length error pulses |
| rx_zlp_i | input | 16 | Receive zero-length packet pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an event that lands in the very cycle software writes a one to clear the same bit. Random traffic rarely lines the two up on the same endpoint. The bench forces it with directed steps for the done register and for a detail register, then checks that the bit survived. It also drives endpoint 0 on every input at once and checks the two-level path: a detail bit is gated by its per-endpoint enable into the summary, then by the exception enable into the interrupt. After that, long runs of sparse random events and random writes are compared against a bench model on every cycle.

// File: rtl/qint_pkg.sv
package qint_pkg;
  localparam int REG_AW = 4;
  localparam int SUM_W  = 5;

  localparam logic [REG_AW-1:0] ADR_DONE_STAT = 4'h0;
  localparam logic [REG_AW-1:0] ADR_DONE_EN   = 4'h1;
  localparam logic [REG_AW-1:0] ADR_EXC_SUM   = 4'h2;
  localparam logic [REG_AW-1:0] ADR_EXC_EN    = 4'h3;
  localparam logic [REG_AW-1:0] ADR_TX_DET    = 4'h4;
  localparam logic [REG_AW-1:0] ADR_RX_DET    = 4'h5;
  localparam logic [REG_AW-1:0] ADR_ZLP_DET   = 4'h6;
  localparam logic [REG_AW-1:0] ADR_TX_EEN    = 4'h7;
  localparam logic [REG_AW-1:0] ADR_RX_EEN    = 4'h8;
  localparam logic [REG_AW-1:0] ADR_ZLP_EEN   = 4'h9;

  // summary bit positions
  localparam int SUM_TX_CS  = 0;
  localparam int SUM_TX_LEN = 1;
  localparam int SUM_RX_CS  = 2;
  localparam int SUM_RX_LEN = 3;
  localparam int SUM_RX_ZLP = 4;
endpackage

// File: rtl/qint_w1c_bank.sv
module qint_w1c_bank #(
  parameter int               WIDTH = 32,
  parameter logic [WIDTH-1:0] VALID = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_mask_i,
  output logic [WIDTH-1:0] stat_o
);
  logic [WIDTH-1:0] stat_q, stat_d, set_v, clr_v;
  logic             upd;

  // set wins over clear: clear is applied first, then events are OR-ed in
  always_comb begin
    set_v  = set_i & VALID;
    clr_v  = clr_we_i ? clr_mask_i : '0;
    stat_d = (stat_q & ~clr_v) | set_v;
    upd    = clr_we_i | (|set_v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/qint_en_reg.sv
module qint_en_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q, q_d;

  always_comb q_d = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (we_i) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/qint_exc_sum.sv
module qint_exc_sum import qint_pkg::*; #(
  parameter int LANE = 16
) (
  input  logic [2*LANE-1:0] tx_det_i,
  input  logic [2*LANE-1:0] tx_en_i,
  input  logic [2*LANE-1:0] rx_det_i,
  input  logic [2*LANE-1:0] rx_en_i,
  input  logic [LANE-1:0]   zlp_det_i,
  input  logic [LANE-1:0]   zlp_en_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic [2*LANE-1:0] tx_live, rx_live;
  logic [LANE-1:0]   zlp_live;

  always_comb begin
    tx_live  = tx_det_i & tx_en_i;
    rx_live  = rx_det_i & rx_en_i;
    zlp_live = zlp_det_i & zlp_en_i;
    sum_o             = '0;
    sum_o[SUM_TX_CS]  = |tx_live[LANE-1:0];
    sum_o[SUM_TX_LEN] = |tx_live[2*LANE-1:LANE];
    sum_o[SUM_RX_CS]  = |rx_live[LANE-1:0];
    sum_o[SUM_RX_LEN] = |rx_live[2*LANE-1:LANE];
    sum_o[SUM_RX_ZLP] = |zlp_live;
  end
endmodule

// File: rtl/qint_agg.sv
module qint_agg import qint_pkg::*; #(
  parameter int NUM_EP = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_EP-1:0]   tx_done_i,
  input  logic [NUM_EP-1:0]   rx_done_i,
  input  logic [NUM_EP-1:0]   tx_cs_err_i,
  input  logic [NUM_EP-1:0]   tx_len_err_i,
  input  logic [NUM_EP-1:0]   rx_cs_err_i,
  input  logic [NUM_EP-1:0]   rx_len_err_i,
  input  logic [NUM_EP-1:0]   rx_zlp_i,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [2*NUM_EP-1:0] reg_wdata_i,
  output logic [2*NUM_EP-1:0] reg_rdata_o,
  output logic                irq_o
);
  localparam int                DW        = 2 * NUM_EP;
  localparam logic [NUM_EP-1:0] LANE_MASK = {{(NUM_EP-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0]     PAIR_MASK = {LANE_MASK, LANE_MASK};

  logic [DW-1:0]     done_q, done_en, tx_det, rx_det, tx_een, rx_een;
  logic [NUM_EP-1:0] zlp_det, zlp_een;
  logic [SUM_W-1:0]  exc_en, exc_sum;
  logic              wr_done, wr_den, wr_een, wr_txd, wr_rxd, wr_zlp;
  logic              wr_txe, wr_rxe, wr_zle;

  always_comb begin
    wr_done = reg_we_i && (reg_addr_i == ADR_DONE_STAT);
    wr_den  = reg_we_i && (reg_addr_i == ADR_DONE_EN);
    wr_een  = reg_we_i && (reg_addr_i == ADR_EXC_EN);
    wr_txd  = reg_we_i && (reg_addr_i == ADR_TX_DET);
    wr_rxd  = reg_we_i && (reg_addr_i == ADR_RX_DET);
    wr_zlp  = reg_we_i && (reg_addr_i == ADR_ZLP_DET);
    wr_txe  = reg_we_i && (reg_addr_i == ADR_TX_EEN);
    wr_rxe  = reg_we_i && (reg_addr_i == ADR_RX_EEN);
    wr_zle  = reg_we_i && (reg_addr_i == ADR_ZLP_EEN);
  end

  // status banks
  qint_w1c_bank #(.WIDTH(DW), .VALID(PAIR_MASK)) u_done (
    .clk_i, .rst_ni, .set_i({rx_done_i, tx_done_i}),
    .clr_we_i(wr_done), .clr_mask_i(reg_wdata_i), .stat_o(done_q));

  qint_w1c_bank #(.WIDTH(DW), .VALID(PAIR_MASK)) u_txdet (
    .clk_i, .rst_ni, .set_i({tx_len_err_i, tx_cs_err_i}),
    .clr_we_i(wr_txd), .clr_mask_i(reg_wdata_i), .stat_o(tx_det));

  qint_w1c_bank #(.WIDTH(DW), .VALID(PAIR_MASK)) u_rxdet (
    .clk_i, .rst_ni, .set_i({rx_len_err_i, rx_cs_err_i}),
    .clr_we_i(wr_rxd), .clr_mask_i(reg_wdata_i), .stat_o(rx_det));

  qint_w1c_bank #(.WIDTH(NUM_EP), .VALID(LANE_MASK)) u_zlpdet (
    .clk_i, .rst_ni, .set_i(rx_zlp_i),
    .clr_we_i(wr_zlp), .clr_mask_i(reg_wdata_i[NUM_EP-1:0]), .stat_o(zlp_det));

  // enable registers
  qint_en_reg #(.WIDTH(DW)) u_den (
    .clk_i, .rst_ni, .we_i(wr_den), .wdata_i(reg_wdata_i), .q_o(done_en));
  qint_en_reg #(.WIDTH(SUM_W)) u_een (
    .clk_i, .rst_ni, .we_i(wr_een), .wdata_i(reg_wdata_i[SUM_W-1:0]), .q_o(exc_en));
  qint_en_reg #(.WIDTH(DW)) u_txe (
    .clk_i, .rst_ni, .we_i(wr_txe), .wdata_i(reg_wdata_i), .q_o(tx_een));
  qint_en_reg #(.WIDTH(DW)) u_rxe (
    .clk_i, .rst_ni, .we_i(wr_rxe), .wdata_i(reg_wdata_i), .q_o(rx_een));
  qint_en_reg #(.WIDTH(NUM_EP)) u_zle (
    .clk_i, .rst_ni, .we_i(wr_zle), .wdata_i(reg_wdata_i[NUM_EP-1:0]), .q_o(zlp_een));

  qint_exc_sum #(.LANE(NUM_EP)) u_sum (
    .tx_det_i(tx_det), .tx_en_i(tx_een), .rx_det_i(rx_det), .rx_en_i(rx_een),
    .zlp_det_i(zlp_det), .zlp_en_i(zlp_een), .sum_o(exc_sum));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_DONE_STAT: reg_rdata_o = done_q;
      ADR_DONE_EN:   reg_rdata_o = done_en;
      ADR_EXC_SUM:   reg_rdata_o = DW'(exc_sum);
      ADR_EXC_EN:    reg_rdata_o = DW'(exc_en);
      ADR_TX_DET:    reg_rdata_o = tx_det;
      ADR_RX_DET:    reg_rdata_o = rx_det;
      ADR_ZLP_DET:   reg_rdata_o = DW'(zlp_det);
      ADR_TX_EEN:    reg_rdata_o = tx_een;
      ADR_RX_EEN:    reg_rdata_o = rx_een;
      ADR_ZLP_EEN:   reg_rdata_o = DW'(zlp_een);
      default:       reg_rdata_o = '0;
    endcase
  end

  always_comb irq_o = (|(done_q & done_en)) | (|(exc_sum & exc_en));
endmodule

// File: rtl/qint_agg_chk.sv
module qint_agg_chk import qint_pkg::*; #(
  parameter int NUM_EP = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_EP-1:0]   tx_done_i,
  input logic [NUM_EP-1:0]   rx_done_i,
  input logic [NUM_EP-1:0]   rx_zlp_i,
  input logic                reg_we_i,
  input logic [REG_AW-1:0]   reg_addr_i,
  input logic [2*NUM_EP-1:0] reg_wdata_i,
  input logic [2*NUM_EP-1:0] done_q,
  input logic [2*NUM_EP-1:0] tx_det,
  input logic [2*NUM_EP-1:0] rx_det,
  input logic [NUM_EP-1:0]   zlp_det,
  input logic                irq_o
);
  localparam int                DW = 2 * NUM_EP;
  localparam logic [NUM_EP-1:0] LM = {{(NUM_EP-1){1'b1}}, 1'b0};

  logic [DW-1:0]     done_ev;
  logic [NUM_EP-1:0] zlp_ev;
  assign done_ev = {rx_done_i & LM, tx_done_i & LM};
  assign zlp_ev  = rx_zlp_i & LM;

  // R4
  ep0_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q[0] && !done_q[NUM_EP] && !tx_det[0] && !tx_det[NUM_EP] &&
    !rx_det[0] && !rx_det[NUM_EP] && !zlp_det[0]);

  // R2
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADR_DONE_STAT)
    |=> ((done_q & $past(reg_wdata_i & ~done_ev)) == '0));

  // R3
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_ev) |=> ((done_q & $past(done_ev)) == $past(done_ev)));

  // R7
  zlp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|zlp_ev) |=> ((zlp_det & $past(zlp_ev)) == $past(zlp_ev)));

  // R5
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q == '0 && tx_det == '0 && rx_det == '0 && zlp_det == '0) |-> !irq_o);
endmodule

bind qint_agg qint_agg_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_done_i(tx_done_i), .rx_done_i(rx_done_i),
  .rx_zlp_i(rx_zlp_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .done_q(done_q), .tx_det(tx_det), .rx_det(rx_det),
  .zlp_det(zlp_det), .irq_o(irq_o));

// File: tb/qint_agg_tb.sv
module qint_agg_tb;
  localparam int NE = 16;
  localparam int DW = 32;
  localparam logic [15:0] LM = 16'hFFFE;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [NE-1:0] tx_done, rx_done, tx_cs, tx_len, rx_cs, rx_len, rx_zlp;
  logic          we;
  logic [3:0]    addr;
  logic [DW-1:0] wdata, rdata;
  logic          irq;

  qint_agg #(.NUM_EP(NE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_done_i(tx_done), .rx_done_i(rx_done),
    .tx_cs_err_i(tx_cs), .tx_len_err_i(tx_len), .rx_cs_err_i(rx_cs),
    .rx_len_err_i(rx_len), .rx_zlp_i(rx_zlp), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [31:0] m_done, m_den, m_txd, m_rxd, m_ten, m_ren;
  logic [15:0] m_zlp, m_zen;
  logic [4:0]  m_een;

  function automatic logic [4:0] f_sum();
    logic [4:0] s;
    s[0] = |(m_txd[15:0]  & m_ten[15:0]);
    s[1] = |(m_txd[31:16] & m_ten[31:16]);
    s[2] = |(m_rxd[15:0]  & m_ren[15:0]);
    s[3] = |(m_rxd[31:16] & m_ren[31:16]);
    s[4] = |(m_zlp & m_zen);
    return s;
  endfunction

  function automatic logic f_irq();
    return (|(m_done & m_den)) | (|(f_sum() & m_een));
  endfunction

  function automatic logic [31:0] f_read(input logic [3:0] a);
    case (a)
      4'h0: return m_done;
      4'h1: return m_den;
      4'h2: return {27'd0, f_sum()};
      4'h3: return {27'd0, m_een};
      4'h4: return m_txd;
      4'h5: return m_rxd;
      4'h6: return {16'd0, m_zlp};
      4'h7: return m_ten;
      4'h8: return m_ren;
      4'h9: return {16'd0, m_zen};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'h0: return "R1/R2";
      4'h2: return "R6";
      4'h4, 4'h5, 4'h6: return "R7/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_done = 0; m_den = 0; m_txd = 0; m_rxd = 0; m_ten = 0; m_ren = 0;
    m_zlp = 0; m_zen = 0; m_een = 0;
  endtask

  task automatic model_update();
    logic [31:0] c0, c4, c5, c6;
    c0 = (we && addr == 4'h0) ? wdata : 32'd0;
    c4 = (we && addr == 4'h4) ? wdata : 32'd0;
    c5 = (we && addr == 4'h5) ? wdata : 32'd0;
    c6 = (we && addr == 4'h6) ? wdata : 32'd0;
    m_done = (m_done & ~c0) | {rx_done & LM, tx_done & LM};
    m_txd  = (m_txd & ~c4) | {tx_len & LM, tx_cs & LM};
    m_rxd  = (m_rxd & ~c5) | {rx_len & LM, rx_cs & LM};
    m_zlp  = (m_zlp & ~c6[15:0]) | (rx_zlp & LM);
    if (we) begin
      case (addr)
        4'h1: m_den = wdata;
        4'h3: m_een = wdata[4:0];
        4'h7: m_ten = wdata;
        4'h8: m_ren = wdata;
        4'h9: m_zen = wdata[15:0];
        default: ;
      endcase
    end
  endtask

  task automatic drive_idle();
    tx_done = 0; rx_done = 0; tx_cs = 0; tx_len = 0; rx_cs = 0; rx_len = 0;
    rx_zlp = 0; we = 0; addr = 0; wdata = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    #1;
    drive_idle();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_rd(input logic [3:0] a, input string tag);
    we = 1'b0; addr = a; #1;
    check(tag, rdata, f_read(a));
  endtask

  task automatic chk_lit(input logic [3:0] a, input logic [31:0] exp, input string tag);
    we = 1'b0; addr = a; #1;
    check(tag, rdata, exp);
    check({tag, " model"}, exp, f_read(a));
  endtask

  task automatic chk_irq(input string tag);
    #1;
    check(tag, {31'd0, irq}, {31'd0, f_irq()});
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    drive_idle();
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state
    for (int a = 0; a < 11; a++) chk_lit(4'(a), 32'd0, "R9 reset");
    check("R5 reset irq", {31'd0, irq}, 32'd0);

    // R1: done layout
    tx_done = 16'h0008; rx_done = 16'h0020; tick();
    chk_lit(4'h0, 32'h0020_0008, "R1 layout");
    chk_irq("R5 masked");
    wr(4'h1, 32'h0000_0008);
    check("R5 enabled irq", {31'd0, irq}, 32'd1);
    chk_rd(4'h1, "R9 done-enable readback");

    // R2: write-1 clear
    wr(4'h0, 32'd0);
    chk_lit(4'h0, 32'h0020_0008, "R2 zero write");
    wr(4'h0, 32'h0000_0008);
    chk_lit(4'h0, 32'h0020_0000, "R2 clear");
    chk_irq("R5 after clear");

    // R3: event beats clear
    tx_done = 16'h0080; rx_done = 16'h0020;
    we = 1'b1; addr = 4'h0; wdata = 32'h0020_0080; tick();
    chk_lit(4'h0, 32'h0020_0080, "R3 set wins");

    // R4: endpoint 0 ignored
    wr(4'h0, 32'hFFFF_FFFF);
    tx_done = 16'h0001; rx_done = 16'h0001; tx_cs = 16'h0001; tx_len = 16'h0001;
    rx_cs = 16'h0001; rx_len = 16'h0001; rx_zlp = 16'h0001; tick();
    chk_lit(4'h0, 32'd0, "R4 done");
    chk_lit(4'h4, 32'd0, "R4 tx detail");
    chk_lit(4'h5, 32'd0, "R4 rx detail");
    chk_lit(4'h6, 32'd0, "R4 zlp detail");

    // R7: detail recording without enables
    tx_cs = 16'h0004; tx_len = 16'h0200; rx_zlp = 16'h8000; tick();
    chk_lit(4'h4, 32'h0200_0004, "R7 tx detail");
    chk_lit(4'h6, 32'h0000_8000, "R7 zlp detail");
    chk_lit(4'h2, 32'd0, "R6 no error enables");

    // R6: summary
    wr(4'h7, 32'h0200_0000);
    chk_lit(4'h2, 32'h0000_0002, "R6 tx length");
    wr(4'h9, 32'h0000_8000);
    chk_lit(4'h2, 32'h0000_0012, "R6 zlp");
    chk_irq("R5 summary masked");
    wr(4'h3, 32'h0000_001F);
    check("R5 summary irq", {31'd0, irq}, 32'd1);
    wr(4'h2, 32'hFFFF_FFFF);
    chk_lit(4'h2, 32'h0000_0012, "R6 read only");

    // R8: detail clear
    wr(4'h4, 32'h0200_0000);
    chk_lit(4'h4, 32'h0000_0004, "R8 tx clear");
    chk_lit(4'h2, 32'h0000_0010, "R8 summary drop");
    wr(4'h6, 32'h0000_8000);
    chk_lit(4'h2, 32'd0, "R8 summary zero");
    chk_irq("R8 irq drop");
    rx_cs = 16'h0010; we = 1'b1; addr = 4'h5; wdata = 32'h0000_0010; tick();
    chk_lit(4'h5, 32'h0000_0010, "R3 detail set wins");

    // R9: widths and unmapped
    wr(4'h9, 32'hFFFF_FFFF);
    chk_lit(4'h9, 32'h0000_FFFF, "R9 zlp enable width");
    chk_lit(4'h3, 32'h0000_001F, "R9 exc enable");
    wr(4'hA, 32'hFFFF_FFFF);
    chk_lit(4'hA, 32'd0, "R9 unmapped");

    // random phase
    for (int i = 0; i < 2000; i++) begin
      tx_done = 16'($urandom & $urandom & $urandom);
      rx_done = 16'($urandom & $urandom & $urandom);
      tx_cs   = 16'($urandom & $urandom & $urandom & $urandom);
      tx_len  = 16'($urandom & $urandom & $urandom & $urandom);
      rx_cs   = 16'($urandom & $urandom & $urandom & $urandom);
      rx_len  = 16'($urandom & $urandom & $urandom & $urandom);
      rx_zlp  = 16'($urandom & $urandom & $urandom & $urandom);
      we      = ($urandom % 3) == 0;
      addr    = 4'($urandom % 11);
      wdata   = ($urandom % 2) ? $urandom : ($urandom & $urandom);
      tick();
      begin
        logic [3:0] ra;
        ra = 4'($urandom % 11);
        chk_rd(ra, {"rnd ", tag_of(ra)});
      end
      chk_irq("rnd R5");
    end

    finish_run();
  end
endmodule